// File: doc/BRIEF.md
# AES-128 Round-Key Expander with Inverse Key Set

This block turns a 128-bit AES cipher key into the full table of round keys and keeps that table in a dual-port key store inside the block. Software-free operation: the key is captured with a load strobe, a start pulse launches the schedule, and one 32-bit word is produced per clock until all eleven round keys (44 words) are stored. At the same time the byte-substituted form of every produced word is saved on the store's second port.

When the start pulse comes with a decrypt-prepare request, a second pass follows. This pass builds the eleven inverse round keys that an equivalent-inverse decryption datapath needs. It reads the saved substituted words back, undoes the substitution, and applies InvMixColumns. The first and last inverse keys are the outer round keys, swapped, and are not mixed. The inverse keys go into a separate region, so the forward keys stay readable. A combinational read port returns any word by region, round and word index.

The controller is a four-state machine. The states are IDLE, EXPAND, INVERT and DONE. The transitions are:
- IDLE→EXPAND on start.
- EXPAND→INVERT after the 44th word when a decrypt set was requested.
- EXPAND→DONE after the 44th word otherwise.
- INVERT→DONE after 48 cycles.
- DONE→IDLE unconditionally.

Top module: `aes128_ksched`

## Requirements
- R1: After reset, busy and done are both 0.
- R2: Forward round 0 equals the loaded key. Word 0 is key bits 127:96 and word 3 is bits 31:0. In a word, byte a0 is bits 31:24.
- R3: For rounds 1 to 10, word 0 is p0 ^ Rot(Sub(p3)) ^ {rc,24'h0} and word j is pj ^ (word j-1) for j = 1..3. Here p is the previous round key, Rot moves bytes [a0,a1,a2,a3] to [a1,a2,a3,a0], and rc starts at 01 and is doubled in GF(2^8), modulo 0x11B, for each next round.
- R4: After start is sampled in IDLE without a decrypt request, busy is high for exactly 44 cycles. Done is then high for exactly one cycle, and then both flags are low.
- R5: With a decrypt request sampled alongside start, inverse key 0 equals forward round key 10 and inverse key 10 equals forward round key 0, word by word.
- R6: For 1 ≤ i ≤ 9, inverse word j of key i equals InvMixColumns of forward word j of round (10 − i). The column bytes a0..a3 are multiplied by the circulant rows {0e,0b,0d,09}.
- R7: With a decrypt request, busy lasts exactly 92 cycles (44 + 48) before the single done cycle.
- R8: The forward region (rd_inv = 0) still holds the full forward schedule after an inverse pass.
- R9: While busy, start and key_load are ignored. The running operation keeps its length, and the captured key is not replaced.
- R10: A read with rd_round greater than 10 returns 32'h0 in either region.
- R11: For key 000102…0f, forward round 10 is 13111d7f e3944a17 f307a78b 4d2b30c5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_load | input | 1 | Capture key_in while idle |
| key_in | input | 128 | Cipher key, first word in bits 127:96 |
| start | input | 1 | Launch the schedule while idle |
| inv_req | input | 1 | With start: also build the inverse key set |
| busy | output | 1 | Operation running |
| done | output | 1 | One-cycle completion pulse |
| rd_inv | input | 1 | Read region: 0 forward keys, 1 inverse keys |
| rd_round | input | 4 | Round index of the read word |
| rd_word | input | 2 | Word index within the round |
| rd_data | output | 32 | Selected key word, combinational |

## Verification
The assertions take for granted that start is sampled only at clock edges, and that rd_round stays within its 4-bit range so that any value above 10 counts as out of range. They also take for granted that a completion is always preceded by a busy period. The stimulus changes inputs only at falling edges. It fires stray start and key_load pulses only while an operation is in flight, and it reads the key store only once done has passed, because data read during busy is not defined.

// File: rtl/aes_ks_pkg.sv
`timescale 1ns/1ps
package aes_ks_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EXPAND,
        S_INVERT,
        S_DONE
    } ks_state_e;

    localparam int WORD_W = 32;
    localparam int BYTES  = WORD_W / 8;

    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] x;
        acc = 8'h00;
        x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = gf_xtime(x);
        end
        return acc;
    endfunction

    // a^254 by repeated squaring; zero maps to zero
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] x;
        r = 8'h01;
        x = a;
        for (int i = 1; i < 8; i++) begin
            x = gf_mul(x, x);
            r = gf_mul(r, x);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
        return 8'((x << n) | (x >> (8 - n)));
    endfunction

    function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
        logic [7:0] b;
        b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] sbox_inv(input logic [7:0] s);
        return gf_inv(rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05);
    endfunction

endpackage

// File: rtl/ks_subword.sv
`timescale 1ns/1ps
module ks_subword
    import aes_ks_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        if (INVERSE) begin : g_inv
            assign dout[8*g +: 8] = sbox_inv(din[8*g +: 8]);
        end else begin : g_fwd
            assign dout[8*g +: 8] = sbox_fwd(din[8*g +: 8]);
        end
    end
endmodule

// File: rtl/ks_invmix.sv
`timescale 1ns/1ps
module ks_invmix
    import aes_ks_pkg::*;
(
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    logic [7:0] col [BYTES];

    for (genvar c = 0; c < BYTES; c++) begin : g_in
        assign col[c] = din[WORD_W-1-8*c -: 8];
    end

    for (genvar r = 0; r < BYTES; r++) begin : g_row
        assign dout[WORD_W-1-8*r -: 8] =
              gf_mul(col[r],                8'h0e)
            ^ gf_mul(col[(r + 1) % BYTES],  8'h0b)
            ^ gf_mul(col[(r + 2) % BYTES],  8'h0d)
            ^ gf_mul(col[(r + 3) % BYTES],  8'h09);
    end
endmodule

// File: rtl/ks_store.sv
`timescale 1ns/1ps
module ks_store
    import aes_ks_pkg::*;
#(
    parameter int WORDS = 44,
    parameter int AW    = 7,
    parameter int SW    = 6
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [AW-1:0]     a_addr,
    input  logic [WORD_W-1:0] a_wdata,
    input  logic [AW-1:0]     r_addr,
    output logic [WORD_W-1:0] r_data,
    input  logic              b_we,
    input  logic [SW-1:0]     b_addr,
    input  logic [WORD_W-1:0] b_wdata,
    output logic [WORD_W-1:0] b_rdata
);
    logic [WORD_W-1:0] key_mem [2*WORDS];
    logic [WORD_W-1:0] sub_mem [WORDS];

    always_ff @(posedge clk) begin
        if (a_we) key_mem[a_addr] <= a_wdata;
    end

    assign r_data = key_mem[r_addr];

    always_ff @(posedge clk) begin
        if (b_we) sub_mem[b_addr] <= b_wdata;
        b_rdata <= sub_mem[b_addr];
    end
endmodule

// File: rtl/aes128_ksched.sv
`timescale 1ns/1ps
module aes128_ksched
    import aes_ks_pkg::*;
#(
    parameter int NR = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_load,
    input  logic [127:0]  key_in,
    input  logic          start,
    input  logic          inv_req,
    output logic          busy,
    output logic          done,
    input  logic          rd_inv,
    input  logic [3:0]    rd_round,
    input  logic [1:0]    rd_word,
    output logic [31:0]   rd_data
);
    localparam int WORDS   = BYTES * (NR + 1);
    localparam int INV_CYC = WORDS + 4;
    localparam int AW      = $clog2(2 * WORDS);
    localparam int SW      = $clog2(WORDS);
    localparam int CW      = $clog2(INV_CYC + 1);

    ks_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [127:0]      key_q;
    logic              inv_q;
    logic [WORD_W-1:0] win_q [BYTES];
    logic [WORD_W-1:0] sub_prev_q;
    logic [7:0]        rcon_q;

    logic [SW-1:0]     ex_k;
    logic [WORD_W-1:0] key_word, mix_t, new_w, sub_new;
    logic              issue;
    logic [SW-1:0]     src_addr;
    logic              a_we, b_we;
    logic [AW-1:0]     a_addr, r_addr;
    logic [WORD_W-1:0] a_wdata, r_data, b_rdata;
    logic [SW-1:0]     b_addr;

    // inverse pipeline: read, inverse substitution, mixing, write staging
    logic              v1_q, v2_q, v3_q, v4_q;
    logic [SW-1:0]     dst1_q, dst2_q, dst3_q, dst4_q;
    logic              pl1_q, pl2_q;
    logic [WORD_W-1:0] d2_q, d3_q, d4_q, isb_w, imc_w;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_EXPAND;
            S_EXPAND: if (cnt_q == CW'(WORDS - 1)) state_d = inv_q ? S_INVERT : S_DONE;
            S_INVERT: if (cnt_q == CW'(INV_CYC - 1)) state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
        endcase
    end

    // outputs and store port control
    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        a_we    = 1'b0;
        a_addr  = AW'(ex_k);
        a_wdata = new_w;
        b_we    = 1'b0;
        b_addr  = ex_k;
        issue   = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_EXPAND: begin
                busy = 1'b1;
                a_we = 1'b1;
                b_we = 1'b1;
            end
            S_INVERT: begin
                busy    = 1'b1;
                issue   = (cnt_q < CW'(WORDS));
                b_addr  = src_addr;
                a_we    = v4_q;
                a_addr  = AW'(WORDS) + AW'(dst4_q);
                a_wdata = d4_q;
            end
            S_DONE: done = 1'b1;
        endcase
    end

    // forward word generation
    assign ex_k     = cnt_q[SW-1:0];
    assign key_word = key_q[127 - 32*int'(ex_k[1:0]) -: 32];
    assign mix_t    = (ex_k[1:0] == 2'd0)
                    ? ({sub_prev_q[23:0], sub_prev_q[31:24]} ^ {rcon_q, 24'h0})
                    : win_q[BYTES-1];
    assign new_w    = (ex_k < SW'(BYTES)) ? key_word : (win_q[0] ^ mix_t);

    ks_subword #(.INVERSE(1'b0)) u_sub_fwd (.din(new_w), .dout(sub_new));

    // inverse key i word j reads the substituted word of round NR-i
    assign src_addr = SW'((NR - int'(cnt_q[CW-1:2])) * BYTES + int'(cnt_q[1:0]));

    ks_subword #(.INVERSE(1'b1)) u_sub_inv (.din(b_rdata), .dout(isb_w));
    ks_invmix u_imc (.din(d2_q), .dout(imc_w));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q      <= '0;
            inv_q      <= 1'b0;
            sub_prev_q <= '0;
            rcon_q     <= 8'h01;
            for (int i = 0; i < BYTES; i++) win_q[i] <= '0;
        end else begin
            if (state_q == S_IDLE) begin
                if (key_load) key_q <= key_in;
                if (start) begin
                    inv_q  <= inv_req;
                    rcon_q <= 8'h01;
                end
            end
            if (state_q == S_EXPAND) begin
                for (int i = 0; i < BYTES - 1; i++) win_q[i] <= win_q[i+1];
                win_q[BYTES-1] <= new_w;
                sub_prev_q     <= sub_new;
                if (ex_k >= SW'(BYTES) && ex_k[1:0] == 2'd0) rcon_q <= gf_xtime(rcon_q);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {v1_q, v2_q, v3_q, v4_q} <= '0;
            {dst1_q, dst2_q, dst3_q, dst4_q} <= '0;
            {pl1_q, pl2_q} <= '0;
            {d2_q, d3_q, d4_q} <= '0;
        end else begin
            v1_q   <= issue;
            dst1_q <= cnt_q[SW-1:0];
            pl1_q  <= (cnt_q[CW-1:2] == '0) || (cnt_q[CW-1:2] == CW'(NR));
            v2_q   <= v1_q;  dst2_q <= dst1_q;  pl2_q <= pl1_q;  d2_q <= isb_w;
            v3_q   <= v2_q;  dst3_q <= dst2_q;  d3_q <= pl2_q ? d2_q : imc_w;
            v4_q   <= v3_q;  dst4_q <= dst3_q;  d4_q <= d3_q;
        end
    end

    assign r_addr  = AW'(rd_inv ? WORDS : 0) + AW'(rd_round) * AW'(BYTES) + AW'(rd_word);
    assign rd_data = (rd_round > 4'(NR)) ? '0 : r_data;

    ks_store #(.WORDS(WORDS), .AW(AW), .SW(SW)) u_store (
        .clk     (clk),
        .a_we    (a_we),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .r_addr  (r_addr),
        .r_data  (r_data),
        .b_we    (b_we),
        .b_addr  (b_addr),
        .b_wdata (sub_new),
        .b_rdata (b_rdata)
    );
endmodule

// File: rtl/aes128_ksched_chk.sv
`timescale 1ns/1ps
module aes128_ksched_chk #(
    parameter int NR = 10
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [3:0]  rd_round,
    input logic [31:0] rd_data
);
    // R4: completion pulse lasts one cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: never busy and done together
    a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R4: busy ends only into a done cycle
    a_r4_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4: done is preceded by busy
    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R9: an operation only begins from a start pulse
    a_r9_launch_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10: out-of-range round reads zero
    a_r10_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_round > 4'(NR)) |-> (rd_data == 32'h0));
endmodule

bind aes128_ksched aes128_ksched_chk #(.NR(NR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .rd_round (rd_round),
    .rd_data  (rd_data)
);

// File: tb/aes128_ksched_tb_top.sv
`timescale 1ns/1ps
module aes128_ksched_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_load = 1'b0;
    logic [127:0] key_in = '0;
    logic         start = 1'b0;
    logic         inv_req = 1'b0;
    logic         busy, done;
    logic         rd_inv = 1'b0;
    logic [3:0]   rd_round = '0;
    logic [1:0]   rd_word = '0;
    logic [31:0]  rd_data;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [31:0] ref_fwd [44];
    logic [31:0] ref_inv [44];

    always #5 clk = ~clk;

    aes128_ksched dut_i (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
        .start(start), .inv_req(inv_req), .busy(busy), .done(done),
        .rd_inv(rd_inv), .rd_round(rd_round), .rd_word(rd_word), .rd_data(rd_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference arithmetic, written from the field definition
    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] bb = b;
        for (int i = 0; i < 8; i++) begin
            if (a[i]) p ^= bb;
            bb = bb[7] ? ((bb << 1) ^ 8'h1b) : (bb << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] bsub(input logic [7:0] x);
        logic [7:0] y = 0;
        logic [7:0] o;
        logic [7:0] c = 8'h63;
        for (int k = 1; k < 256; k++) if (bmul(x, 8'(k)) == 8'h01) y = 8'(k);
        for (int i = 0; i < 8; i++)
            o[i] = y[i] ^ y[(i+4)%8] ^ y[(i+5)%8] ^ y[(i+6)%8] ^ y[(i+7)%8] ^ c[i];
        return o;
    endfunction

    function automatic logic [31:0] bimc(input logic [31:0] w);
        logic [7:0] cb [4];
        logic [7:0] coef [4];
        logic [31:0] o;
        coef[0] = 8'h0e; coef[1] = 8'h0b; coef[2] = 8'h0d; coef[3] = 8'h09;
        for (int j = 0; j < 4; j++) cb[j] = w[31-8*j -: 8];
        for (int r = 0; r < 4; r++) begin
            logic [7:0] acc = 0;
            for (int j = 0; j < 4; j++) acc ^= bmul(coef[(j - r + 4) % 4], cb[j]);
            o[31-8*r -: 8] = acc;
        end
        return o;
    endfunction

    task automatic build_ref(input logic [127:0] k);
        logic [7:0] rc = 8'h01;
        for (int i = 0; i < 4; i++) ref_fwd[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] t = ref_fwd[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {bsub(t[31:24]), bsub(t[23:16]), bsub(t[15:8]), bsub(t[7:0])};
                t ^= {rc, 24'h0};
                rc = bmul(rc, 8'h02);
            end
            ref_fwd[i] = ref_fwd[i-4] ^ t;
        end
        for (int r = 0; r <= 10; r++)
            for (int c = 0; c < 4; c++)
                ref_inv[r*4+c] = (r == 0 || r == 10) ? ref_fwd[(10-r)*4+c]
                                                     : bimc(ref_fwd[(10-r)*4+c]);
    endtask

    task automatic load_key(input logic [127:0] k);
        @(negedge clk);
        key_in = k; key_load = 1'b1;
        @(negedge clk);
        key_load = 1'b0;
    endtask

    // cycle-by-cycle flag model; R9 stray pulses injected mid-run
    task automatic run_op(input bit want_inv);
        int n = want_inv ? 92 : 44;
        logic [127:0] saved = key_in;
        @(negedge clk);
        start = 1'b1; inv_req = want_inv;
        @(negedge clk);
        start = 1'b0; inv_req = 1'b0;
        for (int k = 1; k <= n + 2; k++) begin
            check(want_inv ? "R7 busy" : "R4 busy", 32'(busy), 32'(k <= n));
            check(want_inv ? "R7 done" : "R4 done", 32'(done), 32'(k == n + 1));
            if (k == 10) begin
                start = 1'b1; key_load = 1'b1; key_in = ~saved;
            end
            if (k == 11) begin
                start = 1'b0; key_load = 1'b0; key_in = saved;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_region(input bit inv_region, string req);
        for (int r = 0; r <= 10; r++)
            for (int c = 0; c < 4; c++) begin
                rd_inv = inv_region; rd_round = 4'(r); rd_word = 2'(c);
                #1;
                check(req, rd_data, inv_region ? ref_inv[r*4+c] : ref_fwd[r*4+c]);
            end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", 32'(busy), 32'h0);
        check("R1 done", 32'(done), 32'h0);
        rst_n = 1'b1;

        // FIPS-197 key, forward only
        load_key(128'h000102030405060708090a0b0c0d0e0f);
        build_ref(128'h000102030405060708090a0b0c0d0e0f);
        run_op(1'b0);
        check_region(1'b0, "R2 R3 forward");
        rd_inv = 0; rd_round = 4'd10;
        rd_word = 2'd0; #1; check("R11 w40", rd_data, 32'h13111d7f);
        rd_word = 2'd1; #1; check("R11 w41", rd_data, 32'he3944a17);
        rd_word = 2'd2; #1; check("R11 w42", rd_data, 32'hf307a78b);
        rd_word = 2'd3; #1; check("R11 w43", rd_data, 32'h4d2b30c5);
        rd_round = 4'd11; rd_word = 2'd2; #1; check("R10 fwd round 11", rd_data, 32'h0);
        rd_inv = 1; rd_round = 4'd15; #1; check("R10 inv round 15", rd_data, 32'h0);

        // same captured key (stray load above must not have replaced it), with inverse pass
        run_op(1'b1);
        check_region(1'b1, "R5 R6 R9 inverse");
        check_region(1'b0, "R8 forward kept");
        rd_inv = 1; rd_round = 4'd0; rd_word = 2'd0; #1;
        check("R5 inv0 = rk10", rd_data, 32'h13111d7f);

        // second key, inverse pass
        load_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
        build_ref(128'h2b7e151628aed2a6abf7158809cf4f3c);
        run_op(1'b1);
        check_region(1'b0, "R3 R8 forward key2");
        check_region(1'b1, "R5 R6 inverse key2");

        // all-ones key, inverse pass
        load_key({128{1'b1}});
        build_ref({128{1'b1}});
        run_op(1'b1);
        check_region(1'b0, "R2 R3 forward ones");
        check_region(1'b1, "R6 inverse ones");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #200_000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule